// File: doc/BRIEF.md
# Event Acquisition Window Sequencer

This block sequences a single event for a multi-hit time digitizer. A rising edge on the common start input opens an acquisition window. The window closes when a programmable limit, counted in clock steps, runs out, or earlier when an external stop edge arrives. An optional extension window of programmable length can follow. During both windows the block passes hit edges through and counts them, up to a programmable cap.

Once the windows have closed, the block enters a dead period while the captured data is moved into the buffer. The length of this period grows with the number of recorded hits. BUSY is high for the whole dead period, and a status query is answered positively while BUSY is high. In unbuffered operation BUSY also stays high after the dead period, until the readout logic signals that it is done. A front-panel clear, resampled at half the clock rate, aborts the event and returns the block to idle with no dead period, but only while one of the two windows is open.

Each control input passes through a synchronizer and an edge detector, so every control input is edge-triggered. The TDC conversion, the data storage and the bus protocol sit outside this block.

Top module: `evwin_seq`

## Requirements
- R1: After reset, the block is idle (`state_o` = 0), `busy_o` is low and `hit_cnt_o` is zero. The `state_o` codes are: 0 idle, 1 acquire, 2 extension, 3 dead, 4 wait-for-readout.
- R2: In the idle state, a rising edge on `start_i` reaches the state after synchronization and edge detection, and `state_o` becomes 1 four clock edges after the start level is first sampled.
- R3: The acquire state lasts max(`cfg_limit_i`, 1) cycles. A limit of zero behaves as one step.
- R4: A rising edge on `stop_i` in the acquire state ends acquisition. When the stop level is first sampled in acquire cycle s, the acquire state lasts s+4 cycles, unless the limit expires first.
- R5: When acquisition ends, an extension state of exactly `cfg_ext_i` cycles follows. A value of zero goes straight to the dead state.
- R6: Hit edges are recorded in the acquire and extension states only. A hit level first sampled in window cycle i is recorded when i+4 ≤ (acquire + extension length). `hit_cnt_o` saturates at `cfg_hit_cap_i`, and `hit_acc_o` pulses only for recorded hits, with the lower channel index first.
- R7: The dead state lasts 36 + 2·(recorded hits) cycles. `busy_o` is high throughout, and `stat_ack_o` follows `stat_rd_i` while busy.
- R8: While busy, start, stop, clear and hit edges have no effect: the event ends normally, the block stays idle afterwards and `hit_cnt_o` keeps its value.
- R9: The clear is resampled every second cycle. A clear edge in the acquire or extension state returns the block to idle with no dead state. A clear that arrives during the dead state has no effect.
- R10: With `cfg_buffered_i` high, the block returns to idle after the dead state. With it low, the block holds state 4 with `busy_o` high until a rising edge on `rd_done_i`, and then goes idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock, one timing step per cycle |
| rst_n | input | 1 | Active-low reset |
| cfg_limit_i | input | TO_W | Acquisition limit in clock steps (0 acts as 1) |
| cfg_ext_i | input | MPI_W | Extension window length in clock steps |
| cfg_hit_cap_i | input | HIT_W | Maximum number of recorded hits |
| cfg_buffered_i | input | 1 | 1: release busy after dead time; 0: wait for readout |
| start_i | input | 1 | Asynchronous common start |
| stop_i | input | 1 | Asynchronous external common stop |
| clear_i | input | 1 | Asynchronous front-panel clear |
| hit_i | input | N_CH | Asynchronous hit inputs |
| rd_done_i | input | 1 | Readout finished indication |
| stat_rd_i | input | 1 | Busy status query |
| busy_o | output | 1 | Busy indication |
| stat_ack_o | output | 1 | Positive answer to the status query |
| hit_acc_o | output | N_CH | Pulses for recorded hit edges |
| hit_cnt_o | output | HIT_W | Number of hits recorded in the current event |
| state_o | output | 3 | Debug state code |

## Verification
The bench builds the block with two hit channels, a 3-bit hit counter, a 4-bit limit field and a 3-bit extension field, with the other parameters at their defaults. With these values the bench can sweep every small limit (including zero) against several extension lengths and run the hit cap from zero up to the full 3-bit range. It can also place hits on both sides of the window boundary within a few dozen cycles. The expected window, extension and dead lengths are all computed arithmetically from the stimulus timing.

// File: rtl/evwin_pkg.sv
package evwin_pkg;

   typedef enum logic [2:0] {
      EV_IDLE = 3'd0,
      EV_ACQ  = 3'd1,
      EV_EXT  = 3'd2,
      EV_DEAD = 3'd3,
      EV_HOLD = 3'd4
   } ev_state_e;

   function automatic int imax3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/evwin_edge.sv
module evwin_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic din,
   output logic rise
);

   logic [STAGES-1:0] chain;
   logic              last;

   if (STAGES < 2) begin : g_bad_stages
      $error("evwin_edge: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
         last  <= 1'b0;
         rise  <= 1'b0;
      end else begin
         chain <= {chain[STAGES-2:0], din};
         if (en) begin
            last <= chain[STAGES-1];
            rise <= chain[STAGES-1] & ~last;
         end else begin
            rise <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/evwin_timer.sv
module evwin_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] val,
   output logic [W-1:0] cnt,
   output logic         last
);

   if (W < 2) begin : g_bad_w
      $error("evwin_timer: W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= val;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign last = (cnt == W'(1));

   // R3: an expired timer that is not reloaded stays expired
   assert_tmr_rest_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt == '0) |=> (cnt == '0));

endmodule

// File: rtl/evwin_hitcnt.sv
module evwin_hitcnt #(
   parameter int N_CH  = 8,
   parameter int HIT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  logic [N_CH-1:0]  edges,
   input  logic [HIT_W-1:0] cap,
   output logic [N_CH-1:0]  acc,
   output logic [HIT_W-1:0] cnt,
   output logic [HIT_W-1:0] cnt_nxt
);

   logic [HIT_W-1:0] run;

   if (N_CH < 1) begin : g_bad_ch
      $error("evwin_hitcnt: N_CH must be at least 1");
   end

   always_comb begin
      run = cnt;
      acc = '0;
      for (int i = 0; i < N_CH; i++) begin
         if (en && edges[i] && (run < cap)) begin
            acc[i] = 1'b1;
            run    = run + 1'b1;
         end
      end
      cnt_nxt = run;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else begin
         cnt <= cnt_nxt;
      end
   end

   // R6: once the cap is reached the count does not move until cleared
   assert_hit_sat_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == cap && !clr) |=> (cnt == $past(cnt)));

endmodule

// File: rtl/evwin_seq.sv
module evwin_seq
   import evwin_pkg::*;
#(
   parameter int TO_W         = 8,
   parameter int MPI_W        = 4,
   parameter int HIT_W        = 5,
   parameter int N_CH         = 8,
   parameter int DEAD_BASE    = 36,
   parameter int DEAD_PER_HIT = 2,
   parameter int SYNC_STAGES  = 2,
   parameter int CLR_DIV      = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TO_W-1:0]  cfg_limit_i,
   input  logic [MPI_W-1:0] cfg_ext_i,
   input  logic [HIT_W-1:0] cfg_hit_cap_i,
   input  logic             cfg_buffered_i,
   input  logic             start_i,
   input  logic             stop_i,
   input  logic             clear_i,
   input  logic [N_CH-1:0]  hit_i,
   input  logic             rd_done_i,
   input  logic             stat_rd_i,
   output logic             busy_o,
   output logic             stat_ack_o,
   output logic [N_CH-1:0]  hit_acc_o,
   output logic [HIT_W-1:0] hit_cnt_o,
   output logic [2:0]       state_o
);

   localparam int DEAD_MAX = DEAD_BASE + DEAD_PER_HIT * ((1 << HIT_W) - 1);
   localparam int DEAD_W   = $clog2(DEAD_MAX + 1);
   localparam int TMR_W    = imax3(TO_W, MPI_W, DEAD_W);
   localparam int PH_W     = (CLR_DIV > 1) ? $clog2(CLR_DIV) : 1;

   if (TO_W < 1 || MPI_W < 1 || HIT_W < 1) begin : g_bad_width
      $error("evwin_seq: field widths must be positive");
   end
   if (DEAD_BASE < 1 || DEAD_PER_HIT < 0) begin : g_bad_dead
      $error("evwin_seq: dead time base must be positive");
   end
   if (CLR_DIV < 1) begin : g_bad_div
      $error("evwin_seq: CLR_DIV must be at least 1");
   end

   // clear resampling strobe
   logic clr_strobe;
   if (CLR_DIV > 1) begin : g_clr_div
      logic [PH_W-1:0] ph;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ph <= '0;
         end else if (ph == PH_W'(CLR_DIV - 1)) begin
            ph <= '0;
         end else begin
            ph <= ph + 1'b1;
         end
      end
      assign clr_strobe = (ph == PH_W'(CLR_DIV - 1));
   end else begin : g_clr_full
      assign clr_strobe = 1'b1;
   end

   // input conditioning
   logic start_r, stop_r, clr_r, rd_r;
   logic [N_CH-1:0] hit_r;

   evwin_edge #(.STAGES(SYNC_STAGES)) u_start (
      .clk(clk), .rst_n(rst_n), .en(1'b1), .din(start_i), .rise(start_r));
   evwin_edge #(.STAGES(SYNC_STAGES)) u_stop (
      .clk(clk), .rst_n(rst_n), .en(1'b1), .din(stop_i), .rise(stop_r));
   evwin_edge #(.STAGES(SYNC_STAGES)) u_clear (
      .clk(clk), .rst_n(rst_n), .en(clr_strobe), .din(clear_i), .rise(clr_r));
   evwin_edge #(.STAGES(SYNC_STAGES)) u_rd (
      .clk(clk), .rst_n(rst_n), .en(1'b1), .din(rd_done_i), .rise(rd_r));

   for (genvar g = 0; g < N_CH; g++) begin : g_hit
      evwin_edge #(.STAGES(SYNC_STAGES)) u_hit (
         .clk(clk), .rst_n(rst_n), .en(1'b1), .din(hit_i[g]), .rise(hit_r[g]));
   end

   // sequencer state
   ev_state_e        state, nxt;
   logic             tmr_load;
   logic [TMR_W-1:0] tmr_val, tmr_cnt;
   logic             tmr_last;
   logic             acquiring;
   logic             hit_clr;
   logic [HIT_W-1:0] hit_cnt, hit_nxt;
   logic [TMR_W-1:0] lim_val, ext_val, dead_val;

   assign acquiring = (state == EV_ACQ) || (state == EV_EXT);
   assign hit_clr   = (state == EV_IDLE) && start_r;

   assign lim_val  = (cfg_limit_i == '0) ? TMR_W'(1) : TMR_W'(cfg_limit_i);
   assign ext_val  = TMR_W'(cfg_ext_i);
   assign dead_val = TMR_W'(DEAD_BASE) + TMR_W'(DEAD_PER_HIT) * TMR_W'(hit_nxt);

   always_comb begin
      nxt      = state;
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (state)
         EV_IDLE: begin
            if (start_r) begin
               nxt      = EV_ACQ;
               tmr_load = 1'b1;
               tmr_val  = lim_val;
            end
         end
         EV_ACQ: begin
            if (clr_r) begin
               nxt = EV_IDLE;
            end else if (tmr_last || stop_r) begin
               tmr_load = 1'b1;
               if (cfg_ext_i != '0) begin
                  nxt     = EV_EXT;
                  tmr_val = ext_val;
               end else begin
                  nxt     = EV_DEAD;
                  tmr_val = dead_val;
               end
            end
         end
         EV_EXT: begin
            if (clr_r) begin
               nxt = EV_IDLE;
            end else if (tmr_last) begin
               nxt      = EV_DEAD;
               tmr_load = 1'b1;
               tmr_val  = dead_val;
            end
         end
         EV_DEAD: begin
            if (tmr_last) begin
               nxt = cfg_buffered_i ? EV_IDLE : EV_HOLD;
            end
         end
         EV_HOLD: begin
            if (rd_r) begin
               nxt = EV_IDLE;
            end
         end
         default: nxt = EV_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= EV_IDLE;
      end else begin
         state <= nxt;
      end
   end

   evwin_timer #(.W(TMR_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .val(tmr_val),
      .cnt(tmr_cnt), .last(tmr_last));

   evwin_hitcnt #(.N_CH(N_CH), .HIT_W(HIT_W)) u_hits (
      .clk(clk), .rst_n(rst_n), .clr(hit_clr), .en(acquiring),
      .edges(hit_r), .cap(cfg_hit_cap_i), .acc(hit_acc_o),
      .cnt(hit_cnt), .cnt_nxt(hit_nxt));

   assign busy_o     = (state == EV_DEAD) || (state == EV_HOLD);
   assign stat_ack_o = stat_rd_i & busy_o;
   assign hit_cnt_o  = hit_cnt;
   assign state_o    = state;

   // R9: a qualified clear inside a window aborts straight to idle
   assert_clear_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (((state == EV_ACQ) || (state == EV_EXT)) && clr_r) |=> (state == EV_IDLE));

   // R7: dead period length matches the recorded hit count on entry
   assert_dead_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == EV_DEAD && $past(state) != EV_DEAD) |->
      (int'(tmr_cnt) == DEAD_BASE + DEAD_PER_HIT * int'(hit_cnt)));

   // R8: a start edge while busy never opens a window
   assert_busy_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_r) |=> (state != EV_ACQ));

   // R10: the readout wait is left only on a readout edge
   assert_hold_wait_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state == EV_HOLD && !rd_r) |=> (state == EV_HOLD));

   // R6: no hit is recorded outside the windows
   assert_hit_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_acc_o != '0) |-> ((state == EV_ACQ) || (state == EV_EXT)));

endmodule

// File: tb/evwin_seq_tb_top.sv
`timescale 1ns/1ps
module evwin_seq_tb_top;

   localparam int TO_W  = 4;
   localparam int MPI_W = 3;
   localparam int HIT_W = 3;
   localparam int N_CH  = 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [TO_W-1:0]  cfg_limit_i = '0;
   logic [MPI_W-1:0] cfg_ext_i = '0;
   logic [HIT_W-1:0] cfg_hit_cap_i = '0;
   logic             cfg_buffered_i = 1'b1;
   logic             start_i = 1'b0, stop_i = 1'b0, clear_i = 1'b0;
   logic [N_CH-1:0]  hit_i = '0;
   logic             rd_done_i = 1'b0, stat_rd_i = 1'b0;
   logic             busy_o, stat_ack_o;
   logic [N_CH-1:0]  hit_acc_o;
   logic [HIT_W-1:0] hit_cnt_o;
   logic [2:0]       state_o;

   int nchecks = 0;
   int nerr = 0;

   always #4 clk = ~clk;

   evwin_seq #(.TO_W(TO_W), .MPI_W(MPI_W), .HIT_W(HIT_W), .N_CH(N_CH)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_limit_i(cfg_limit_i), .cfg_ext_i(cfg_ext_i),
      .cfg_hit_cap_i(cfg_hit_cap_i), .cfg_buffered_i(cfg_buffered_i),
      .start_i(start_i), .stop_i(stop_i), .clear_i(clear_i), .hit_i(hit_i),
      .rd_done_i(rd_done_i), .stat_rd_i(stat_rd_i), .busy_o(busy_o),
      .stat_ack_o(stat_ack_o), .hit_acc_o(hit_acc_o), .hit_cnt_o(hit_cnt_o),
      .state_o(state_o));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchecks++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
      $finish;
   endtask

   // one event; positions are window cycles counted from the first acquire cycle
   task automatic run_ev(input int to, input int ext, input int cap, input int nh,
                         input int hb, input int stop_at, input int clr_at,
                         input bit buffered, input bit poke, input bit exp_abort);
      int lim, ev, st, nacq, next, ndead, hdead, guard, exp_acq, exp_hits, win;
      bit done, saw_wait;
      logic [N_CH-1:0] hv;
      lim = (to == 0) ? 1 : to;
      @(negedge clk);
      cfg_limit_i    = TO_W'(to);
      cfg_ext_i      = MPI_W'(ext);
      cfg_hit_cap_i  = HIT_W'(cap);
      cfg_buffered_i = buffered;
      start_i = 1'b1;
      @(negedge clk);
      @(negedge clk);
      start_i = 1'b0;
      guard = 0;
      while (state_o != 3'd1 && guard < 20) begin
         @(negedge clk);
         guard++;
      end
      chk(guard < 20, "R2 start opens acquire", guard, 1);
      ev = 0; nacq = 0; next = 0; ndead = 0; hdead = -1;
      done = 0; saw_wait = 0;
      while (!done && ev < 800) begin
         st = int'(state_o);
         case (st)
            1: nacq++;
            2: next++;
            3: begin
               if (ndead == 0) hdead = int'(hit_cnt_o);
               ndead++;
            end
            4: saw_wait = 1;
            default: done = 1;
         endcase
         if (saw_wait) done = 1;
         if (!done) begin
            hv = '0;
            for (int j = 0; j < nh; j++) if (ev == hb + 2*j) hv[j % 2] = 1'b1;
            stop_i  = (stop_at >= 0) && (ev == stop_at || ev == stop_at + 1);
            clear_i = (clr_at >= 0) && (ev >= clr_at) && (ev < clr_at + 4);
            start_i = 1'b0;
            if (poke && st == 3 && (ndead == 6 || ndead == 7)) begin
               start_i = 1'b1; stop_i = 1'b1; clear_i = 1'b1; hv = '1;
            end
            hit_i = hv;
            stat_rd_i = (st == 3 && ndead == 10);
            if (stat_rd_i) begin
               #1;
               chk(stat_ack_o == 1'b1, "R7 status query while busy", int'(stat_ack_o), 1);
               chk(busy_o == 1'b1, "R7 busy in dead state", int'(busy_o), 1);
            end
            @(negedge clk);
            ev++;
         end
      end
      hit_i = '0; stop_i = 1'b0; clear_i = 1'b0; start_i = 1'b0; stat_rd_i = 1'b0;
      if (saw_wait) begin
         repeat (20) @(negedge clk);
         chk(state_o == 3'd4, "R10 unbuffered holds", int'(state_o), 4);
         chk(busy_o == 1'b1, "R10 busy while waiting", int'(busy_o), 1);
         rd_done_i = 1'b1;
         repeat (2) @(negedge clk);
         rd_done_i = 1'b0;
         repeat (6) @(negedge clk);
         chk(state_o == 3'd0, "R10 readout releases", int'(state_o), 0);
      end else begin
         repeat (8) @(negedge clk);
         chk(state_o == 3'd0, poke ? "R8 stays idle after busy pokes" : "R10 idle after event",
             int'(state_o), 0);
      end
      if (exp_abort) begin
         chk(ndead == 0, "R9 clear skips dead state", ndead, 0);
      end else begin
         exp_acq = (stop_at >= 0 && stop_at + 4 < lim) ? stop_at + 4 : lim;
         chk(nacq == exp_acq, (stop_at >= 0) ? "R4 stop length" : "R3 acquire length",
             nacq, exp_acq);
         chk(next == ext, "R5 extension length", next, ext);
         win = exp_acq + ext;
         exp_hits = 0;
         for (int j = 0; j < nh; j++) if (hb + 2*j + 4 <= win) exp_hits++;
         if (exp_hits > cap) exp_hits = cap;
         chk(hdead == exp_hits, "R6 recorded hits", hdead, exp_hits);
         chk(ndead == 36 + 2*exp_hits, "R7 dead length", ndead, 36 + 2*exp_hits);
         chk(int'(hit_cnt_o) == exp_hits, "R8 count kept after busy", int'(hit_cnt_o), exp_hits);
         chk(saw_wait == !buffered, "R10 mode selects readout wait", int'(saw_wait), int'(!buffered));
      end
   endtask

   initial begin
      #(8 * 150000);
      nerr++;
      nchecks++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(state_o == 3'd0, "R1 reset state", int'(state_o), 0);
      chk(busy_o == 1'b0, "R1 reset busy", int'(busy_o), 0);
      chk(hit_cnt_o == '0, "R1 reset count", int'(hit_cnt_o), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      stat_rd_i = 1'b1;
      #1;
      chk(stat_ack_o == 1'b0, "R7 no ack when idle", int'(stat_ack_o), 0);
      stat_rd_i = 1'b0;
      // R3 R5: limit and extension sweep, including a limit of zero
      for (int t = 0; t <= 6; t++)
         for (int m = 0; m <= 2; m++)
            run_ev(t, m, 7, 0, 1, -1, -1, 1'b1, 1'b0, 1'b0);
      // R6: hit counts inside one long window
      for (int n = 0; n <= 6; n++)
         run_ev(15, 0, 7, n, 1, -1, -1, 1'b1, 1'b0, 1'b0);
      run_ev(15, 0, 3, 6, 1, -1, -1, 1'b1, 1'b0, 1'b0);
      run_ev(15, 1, 0, 2, 1, -1, -1, 1'b1, 1'b0, 1'b0);
      run_ev(10, 0, 7, 4, 1, -1, -1, 1'b1, 1'b0, 1'b0);
      run_ev(2, 6, 7, 3, 1, -1, -1, 1'b1, 1'b0, 1'b0);
      // R4: external stop
      run_ev(15, 0, 7, 0, 1, 3, -1, 1'b1, 1'b0, 1'b0);
      run_ev(15, 2, 7, 2, 0, 5, -1, 1'b1, 1'b0, 1'b0);
      // R9: clear in acquire, in extension, and too late
      run_ev(15, 0, 7, 0, 1, -1, 2, 1'b1, 1'b0, 1'b1);
      run_ev(2, 7, 7, 0, 1, -1, 3, 1'b1, 1'b0, 1'b1);
      run_ev(2, 0, 7, 0, 1, -1, 6, 1'b1, 1'b0, 1'b0);
      // R8: front-panel pokes while busy
      run_ev(3, 0, 7, 0, 1, -1, -1, 1'b1, 1'b1, 1'b0);
      run_ev(12, 1, 7, 2, 1, -1, -1, 1'b1, 1'b1, 1'b0);
      // R10: unbuffered mode
      run_ev(4, 1, 7, 0, 1, -1, -1, 1'b0, 1'b0, 1'b0);
      run_ev(12, 0, 7, 3, 1, -1, -1, 1'b0, 1'b1, 1'b0);
      summary();
   end

endmodule